// File: doc/BRIEF.md
# Serial Audio Slot Formatter

This block turns one stereo frame per sample period into a serial bit stream. It generates its own bit clock, 64 bit periods per frame, and a frame clock that tells which channel is on the line. Each channel occupies a 32-bit slot. The 24-bit sample goes out least significant bit first. Four per-sample flags follow it: validity, user, channel status and block sync. Four zero bits close the slot. The left slot comes before the right slot.

The parallel samples and their flags are held in a shadow register. The shadow is loaded on the bit-clock edge that starts a new frame, so a producer may change its inputs at any other time without corrupting the frame in progress. A receiver for an auxiliary serial input can be enabled by a parameter. It uses the same slot layout and the block's own clocks, and it hands each received frame back in parallel form with a one-cycle strobe. Line coding and preambles are not part of the block.

Top module: `slotfmt_top`

## Requirements
- R1: The bit clock is a square wave with a period of 2*HALF_DIV system clocks. Each half lasts HALF_DIV clocks. One frame spans 64 bit periods.
- R2: The frame clock is high for frame bits 0 to 31 (left slot) and low for bits 32 to 63 (right slot). It changes only together with a falling bit-clock edge.
- R3: Serial data changes only together with a falling bit-clock edge, so a receiver samples it on the rising edge.
- R4: Slot bits 0 to 23 carry the channel sample, least significant bit first.
- R5: Slot bits 24, 25, 26 and 27 carry flag inputs [0] (validity), [1] (user), [2] (channel status) and [3] (block sync). The block-sync flag is passed through unchanged.
- R6: Slot bits 28 to 31 are always zero.
- R7: The left slot (left sample and left flags) occupies frame bits 0 to 31, and the right slot occupies frame bits 32 to 63.
- R8: The inputs are captured on the falling bit-clock edge that starts frame bit 0. Input changes before that edge appear in the new frame. Changes after it do not affect that frame.
- R9: The auxiliary input is sampled on each rising bit-clock edge, using the layout of R4 to R7. On the rising edge of frame bit 63, the receive outputs show that frame and the receive strobe goes high for exactly one system clock. The strobe stays low at all other times, including before the first complete frame after reset.
- R10: During reset the bit clock, frame clock, serial data, receive strobe and receive outputs are all zero. After reset, the first falling bit-clock edge starts frame bit 0, which is preceded by exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| left_i | input | SAMPLE_W | Left channel sample |
| right_i | input | SAMPLE_W | Right channel sample |
| left_flags_i | input | 4 | Left flags: [0] validity, [1] user, [2] channel status, [3] block sync |
| right_flags_i | input | 4 | Right flags, same encoding |
| aux_i | input | 1 | Auxiliary serial data in |
| bclk_o | output | 1 | Bit clock, 64 periods per frame |
| lrck_o | output | 1 | Frame clock, high during the left slot |
| sdo_o | output | 1 | Serial data out |
| rx_left_o | output | SAMPLE_W | Received left sample |
| rx_right_o | output | SAMPLE_W | Received right sample |
| rx_left_flags_o | output | 4 | Received left flags |
| rx_right_flags_o | output | 4 | Received right flags |
| rx_valid_o | output | 1 | One-cycle strobe when a received frame is published |

## Verification
The shadow capture of a new frame's inputs and the output of that frame's first serial bit happen on the same clock edge. An input change that lands just before that edge therefore decides which frame it joins. The bench provokes this by changing the inputs immediately after the last rising edge of a frame, and again just after the capturing falling edge. It also changes them in the middle of a frame. In each case the serialized bits are compared with the vector that should have been held at capture. In loopback, the receiver's publish on the last rising edge coincides with the transmitter's last bit. The bench judges it by requiring the parallel receive outputs to equal the frame just transmitted.

// File: rtl/slotfmt_pkg.sv
package slotfmt_pkg;

  // Flag order within a slot, right after the sample:
  // [0] validity, [1] user, [2] channel status, [3] block sync
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    FLD_SAMPLE,
    FLD_FLAG,
    FLD_PAD
  } field_e;

  // Which field a given slot bit index belongs to
  function automatic field_e field_of(input int k, input int sample_w);
    if (k < sample_w) return FLD_SAMPLE;
    if (k < sample_w + FLAG_W) return FLD_FLAG;
    return FLD_PAD;
  endfunction

  // Position of the next bit within a frame, wrapping at the end
  function automatic int frame_pos_next(input int pos, input int frame_bits);
    return (pos == frame_bits - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/slotfmt_clkgen.sv
module slotfmt_clkgen #(
  parameter int HALF_DIV  = 2,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int CNT_W      = $clog2(HALF_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             fall_evt_o,
  output logic             rise_evt_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] next_pos_o
);

  logic [CNT_W-1:0] hcnt_q;
  logic             bclk_q;
  logic             lrck_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  logic             wrap;

  assign wrap          = (hcnt_q == CNT_W'(HALF_DIV - 1));
  assign fall_evt_o    = wrap & bclk_q;
  assign rise_evt_o    = wrap & ~bclk_q;
  assign pos_nx        = POS_W'(slotfmt_pkg::frame_pos_next(int'(pos_q), FRAME_BITS));
  assign frame_start_o = fall_evt_o && (pos_q == POS_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      pos_q  <= POS_W'(FRAME_BITS - 1);
    end else begin
      hcnt_q <= wrap ? '0 : hcnt_q + 1'b1;
      if (wrap) bclk_q <= ~bclk_q;
      if (fall_evt_o) begin
        pos_q  <= pos_nx;
        lrck_q <= (pos_nx < POS_W'(SLOT_BITS));
      end
    end
  end

  assign bclk_o     = bclk_q;
  assign lrck_o     = lrck_q;
  assign pos_o      = pos_q;
  assign next_pos_o = pos_nx;

  // R1: the bit clock flips only after a full half period
  assert_bclk_half_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(bclk_q) |-> $past(wrap));

  // R2: the frame clock moves only with a falling bit-clock edge
  assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_q) |-> $past(fall_evt_o));

  // R2: the frame clock rises exactly at frame bit 0
  assert_lrck_rise_pos_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lrck_q) |-> (pos_q == '0));

endmodule

// File: rtl/slotfmt_tx.sv
module slotfmt_tx #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_evt_i,
  input  logic                frame_start_i,
  input  logic [POS_W-1:0]    next_pos_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [3:0]          left_flags_i,
  input  logic [3:0]          right_flags_i,
  output logic                sdo_o
);

  logic [FRAME_BITS-1:0] live_frame;
  logic [FRAME_BITS-1:0] shadow_q;
  logic                  sdo_q;

  // Slot layout: sample, then flags, then zero padding; left slot first
  for (genvar k = 0; k < SLOT_BITS; k++) begin : g_slot
    if (slotfmt_pkg::field_of(k, SAMPLE_W) == slotfmt_pkg::FLD_SAMPLE) begin : g_smp
      assign live_frame[k]             = left_i[k];
      assign live_frame[SLOT_BITS + k] = right_i[k];
    end else if (slotfmt_pkg::field_of(k, SAMPLE_W) == slotfmt_pkg::FLD_FLAG) begin : g_flg
      assign live_frame[k]             = left_flags_i[k - SAMPLE_W];
      assign live_frame[SLOT_BITS + k] = right_flags_i[k - SAMPLE_W];
    end else begin : g_pad
      assign live_frame[k]             = 1'b0;
      assign live_frame[SLOT_BITS + k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      sdo_q    <= 1'b0;
    end else if (fall_evt_i) begin
      if (frame_start_i) begin
        shadow_q <= live_frame;
        sdo_q    <= live_frame[0];
      end else begin
        sdo_q <= shadow_q[next_pos_i];
      end
    end
  end

  assign sdo_o = sdo_q;

  // R3: serial data moves only with a falling bit-clock edge
  assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_q) |-> $past(fall_evt_i));

  // R8: the shadow is reloaded only at the start of a frame
  assert_shadow_at_start_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(shadow_q) |-> $past(frame_start_i));

endmodule

// File: rtl/slotfmt_rx.sv
module slotfmt_rx #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_evt_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                aux_i,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic [3:0]          rx_left_flags_o,
  output logic [3:0]          rx_right_flags_o,
  output logic                rx_valid_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] buf_q;
  logic [FRAME_BITS-1:0] full;
  logic                  armed_q;
  logic                  publish;

  always_comb begin
    full                 = buf_q;
    full[FRAME_BITS-1]   = aux_i;
  end

  assign publish = rise_evt_i && (pos_i == LAST_POS) && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q            <= '0;
      armed_q          <= 1'b0;
      rx_left_o        <= '0;
      rx_right_o       <= '0;
      rx_left_flags_o  <= '0;
      rx_right_flags_o <= '0;
      rx_valid_o       <= 1'b0;
    end else begin
      rx_valid_o <= publish;
      if (rise_evt_i) begin
        buf_q[pos_i] <= aux_i;
        if (pos_i == '0) armed_q <= 1'b1;
      end
      if (publish) begin
        rx_left_o        <= full[SAMPLE_W-1:0];
        rx_left_flags_o  <= full[SAMPLE_W +: 4];
        rx_right_o       <= full[SLOT_BITS +: SAMPLE_W];
        rx_right_flags_o <= full[SLOT_BITS + SAMPLE_W +: 4];
      end
    end
  end

  // R9: the strobe lasts one clock
  assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R9: the strobe follows the rising edge of the last frame bit
  assert_rx_at_last_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> ($past(rise_evt_i) && ($past(pos_i) == LAST_POS)));

endmodule

// File: rtl/slotfmt_top.sv
module slotfmt_top #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int HALF_DIV  = 2,
  parameter bit RX_EN     = 1'b1,
  localparam int FRAME_BITS = 2 * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [3:0]          left_flags_i,
  input  logic [3:0]          right_flags_i,
  input  logic                aux_i,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdo_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic [3:0]          rx_left_flags_o,
  output logic [3:0]          rx_right_flags_o,
  output logic                rx_valid_o
);

  logic             fall_evt;
  logic             rise_evt;
  logic             frame_start;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;

  slotfmt_clkgen #(.HALF_DIV(HALF_DIV), .SLOT_BITS(SLOT_BITS)) u_clkgen (
    .clk           (clk),
    .rst           (rst),
    .bclk_o        (bclk_o),
    .lrck_o        (lrck_o),
    .fall_evt_o    (fall_evt),
    .rise_evt_o    (rise_evt),
    .frame_start_o (frame_start),
    .pos_o         (pos),
    .next_pos_o    (next_pos)
  );

  slotfmt_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk           (clk),
    .rst           (rst),
    .fall_evt_i    (fall_evt),
    .frame_start_i (frame_start),
    .next_pos_i    (next_pos),
    .left_i        (left_i),
    .right_i       (right_i),
    .left_flags_i  (left_flags_i),
    .right_flags_i (right_flags_i),
    .sdo_o         (sdo_o)
  );

  if (RX_EN) begin : g_rx
    slotfmt_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_rx (
      .clk              (clk),
      .rst              (rst),
      .rise_evt_i       (rise_evt),
      .pos_i            (pos),
      .aux_i            (aux_i),
      .rx_left_o        (rx_left_o),
      .rx_right_o       (rx_right_o),
      .rx_left_flags_o  (rx_left_flags_o),
      .rx_right_flags_o (rx_right_flags_o),
      .rx_valid_o       (rx_valid_o)
    );
  end else begin : g_no_rx
    logic unused_rx;
    assign unused_rx        = aux_i ^ rise_evt;
    assign rx_left_o        = '0;
    assign rx_right_o       = '0;
    assign rx_left_flags_o  = '0;
    assign rx_right_flags_o = '0;
    assign rx_valid_o       = 1'b0;
  end

endmodule

// File: tb/slotfmt_top_tb.sv
module slotfmt_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int SAMPLE_W   = 24;
  localparam int NVEC       = 6;
  localparam int WD_LIMIT   = 100000;

  // {left[23:0], right[23:0], left_flags[3:0], right_flags[3:0]}
  localparam logic [55:0] VEC_TAB [NVEC] = '{
    {24'h000001, 24'h800000, 4'h1, 4'h8},
    {24'hFFFFFF, 24'h000000, 4'hF, 4'h0},
    {24'hA5A5A5, 24'h5A5A5A, 4'h5, 4'hA},
    {24'h123456, 24'h654321, 4'h2, 4'h4},
    {24'h000000, 24'hFFFFFF, 4'h0, 4'hF},
    {24'h800001, 24'h7FFFFE, 4'h9, 4'h6}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [SAMPLE_W-1:0] left_i = '0, right_i = '0;
  logic [3:0]          lf_i = '0, rf_i = '0;
  logic                loop_sel = 1'b1, aux_bench = 1'b0;
  logic                aux;
  logic                bclk, lrck, sdo, rxv;
  logic [SAMPLE_W-1:0] rxl, rxr;
  logic [3:0]          rxlf, rxrf;

  assign aux = loop_sel ? sdo : aux_bench;

  slotfmt_top #(.SAMPLE_W(SAMPLE_W), .HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .left_i(left_i), .right_i(right_i),
    .left_flags_i(lf_i), .right_flags_i(rf_i), .aux_i(aux),
    .bclk_o(bclk), .lrck_o(lrck), .sdo_o(sdo),
    .rx_left_o(rxl), .rx_right_o(rxr), .rx_left_flags_o(rxlf),
    .rx_right_flags_o(rxrf), .rx_valid_o(rxv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int wd = 0;
  int ncyc = 0, last_rise = 0;
  bit gap_ok = 0, rose = 0;
  int r1_bad = 0, r2_bad = 0, r3_bad = 0;
  logic last_bclk = 0, last_sdo = 0, last_lrck = 0;
  logic [63:0] frm;
  logic        c_rxv;
  logic [SAMPLE_W-1:0] c_rxl, c_rxr;
  logic [3:0]  c_rxlf, c_rxrf;

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [55:0] v);
    {left_i, right_i, lf_i, rf_i} = v;
  endtask

  // independent model: frame bit b is bit b of this vector
  function automatic logic [63:0] exp_frame(input logic [55:0] v);
    return {4'h0, v[3:0], v[31:8], 4'h0, v[7:4], v[55:32]};
  endfunction

  task automatic tick();
    @(negedge clk);
    ncyc++;
    rose = bclk && !last_bclk;
    if (sdo !== last_sdo && !(last_bclk && !bclk)) r3_bad++;
    if (lrck !== last_lrck && !(last_bclk && !bclk)) r2_bad++;
    if (rose) begin
      if (gap_ok && (ncyc - last_rise) != 2*HALF_DIV) r1_bad++;
      gap_ok = 1;
      last_rise = ncyc;
    end
    last_bclk = bclk; last_sdo = sdo; last_lrck = lrck;
  endtask

  task automatic next_rise();
    do tick(); while (!rose);
  endtask

  task automatic collect(input int chg);
    for (int b = 0; b < 64; b++) begin
      next_rise();
      frm[b] = sdo;
      if (lrck !== (b < 32)) r2_bad++;
      if (b == 10 && chg >= 0) apply(VEC_TAB[chg]);
    end
    c_rxv = rxv; c_rxl = rxl; c_rxr = rxr; c_rxlf = rxlf; c_rxrf = rxrf;
  endtask

  task automatic check_frame(input logic [55:0] v, input bit rx_chk);
    logic [63:0] e;
    e = exp_frame(v);
    chk(frm[23:0] == v[55:32] && frm[55:32] == v[31:8], "R4 samples LSB first", frm, e);
    chk(frm[27:24] == v[7:4] && frm[59:56] == v[3:0], "R5 flags V,U,C,B", frm, e);
    chk(frm[31:28] == 4'h0 && frm[63:60] == 4'h0, "R6 pad bits zero", frm, e);
    chk(frm == e, "R7 left slot then right slot", frm, e);
    chk(r1_bad == 0, "R1 bit clock period", 64'(r1_bad), 0);
    chk(r2_bad == 0, "R2 frame clock", 64'(r2_bad), 0);
    chk(r3_bad == 0, "R3 data on falling edge", 64'(r3_bad), 0);
    if (rx_chk)
      chk(c_rxv && {c_rxl, c_rxr, c_rxlf, c_rxrf} == v, "R9 loopback receive",
          {7'h0, c_rxv, c_rxl, c_rxr, c_rxlf, c_rxrf}, {8'h01, v});
  endtask

  task automatic do_reset();
    int n;
    rst = 1'b1;
    repeat (3) tick();
    chk(!bclk && !lrck && !sdo, "R10 reset clocks and data", {bclk, lrck, sdo}, 0);
    chk(!rxv && rxl == 0 && rxr == 0 && rxlf == 0 && rxrf == 0, "R10 reset receive",
        {rxv, rxl, rxr, rxlf, rxrf}, 0);
    rst = 1'b0;
    r1_bad = 0; r2_bad = 0; r3_bad = 0; gap_ok = 0;
    n = 0;
    do begin tick(); if (rose) n++; end while (!lrck);
    chk(n == 1, "R10 one rising edge before frame bit 0", 64'(n), 1);
    r2_bad = 0; r3_bad = 0;
  endtask

  initial begin
    apply(VEC_TAB[0]);
    do_reset();

    // table walk; next vector applied mid-frame (R8: ignored by current frame)
    for (int i = 0; i < NVEC; i++) begin
      collect((i + 1) % NVEC);
      check_frame(VEC_TAB[i], 1'b1);
      chk(frm == exp_frame(VEC_TAB[i]), "R8 mid-frame change ignored", frm, exp_frame(VEC_TAB[i]));
    end

    // change right after the last rising edge: joins the next frame (R8)
    apply(VEC_TAB[3]);
    collect(-1);
    chk(frm == exp_frame(VEC_TAB[3]), "R8 change before capture edge", frm, exp_frame(VEC_TAB[3]));

    // change just after the capture edge: frame keeps old vector (R8)
    do tick(); while (!lrck);
    apply(VEC_TAB[4]);
    collect(-1);
    chk(frm == exp_frame(VEC_TAB[3]), "R8 change after capture edge", frm, exp_frame(VEC_TAB[3]));
    collect(-1);
    check_frame(VEC_TAB[4], 1'b1);

    // auxiliary input held high: every field received as ones (R9)
    loop_sel = 1'b0; aux_bench = 1'b1;
    collect(-1);
    collect(-1);
    check_frame(VEC_TAB[4], 1'b0);
    chk(c_rxv && c_rxl == '1 && c_rxr == '1 && c_rxlf == 4'hF && c_rxrf == 4'hF,
        "R9 aux all ones", {c_rxv, c_rxl, c_rxr, c_rxlf, c_rxrf}, {1'b1, 56'hFFFFFFFFFFFFFF});

    // reset in mid-frame, then realignment (R10)
    loop_sel = 1'b1; aux_bench = 1'b0;
    repeat (20) next_rise();
    do_reset();
    collect(-1);
    check_frame(VEC_TAB[4], 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule